// File: doc/BRIEF.md
# Byte-FIFO UART Register Front-End

This block is the software-facing half of a simple serial port. It sits on a 32-bit bus with word-aligned byte addresses. It keeps one byte queue for outgoing data and one for incoming data. A serial engine, which is outside this block, drains the outgoing queue and fills the incoming queue through byte-wide valid/ready handshakes. The block also supplies the engine with its enable bits, the stop-bit choice and a 16-bit clock divisor.

Software sends a byte by writing the transmit-data word. It takes a byte by reading the receive-data word, and that read removes the byte from the queue. Each queue has a 3-bit watermark, and the two comparisons run in opposite directions. The transmit condition is true while the transmit queue holds fewer entries than its watermark. The receive condition is true while the receive queue holds more entries than its watermark. The pending bits follow the queue levels every cycle. After masking with the enable bits, they are merged into a single interrupt line.

Top module: `sio_fifo_regs`

## Requirements
- R1: After reset, every register reads as zero and both queues are empty. The receive-data word therefore reads 0x8000_0000, and irq_o, tx_valid_o and rx_ready_o are low.
- R2: A write to offset 0x00 queues bits 7:0. The engine side presents the queued bytes in write order, but only while the transmit enable is 1. A byte leaves the queue on a cycle where tx_valid_o and tx_ready_i are both high.
- R3: A read of offset 0x00 returns the queue-full flag in bit 31 and zeros in all other bits. A write made while the queue holds 8 bytes is discarded, and the stored bytes stay unchanged.
- R4: A read of offset 0x04 returns the head byte in bits 7:0, with bit 31 clear, and removes that byte from the queue. When the queue is empty, the read returns 0x8000_0000 and removes nothing.
- R5: rx_ready_o is high exactly while the receive enable is 1 and the receive queue holds fewer than 8 bytes. A byte is taken in when rx_valid_i and rx_ready_o are both high.
- R6: Offset 0x08 holds the transmit enable in bit 0, the stop select in bit 1 (0 selects one stop bit, 1 selects two) and the transmit watermark in bits 18:16. Other bits read as 0. tx_en_o and two_stop_o follow bit 0 and bit 1.
- R7: Offset 0x0C holds the receive enable in bit 0 and the receive watermark in bits 18:16. Other bits read as 0. rx_en_o follows bit 0.
- R8: Pending bit 0 at offset 0x14 is 1 while the transmit queue level is strictly less than the transmit watermark.
- R9: Pending bit 1 at offset 0x14 is 1 while the receive queue level is strictly greater than the receive watermark.
- R10: irq_o is the OR over both bits of (pending AND enable), where the enable bits are at offset 0x10 with bit 0 for transmit and bit 1 for receive. A write to offset 0x14 has no effect.
- R11: Offset 0x18 holds a 16-bit divisor in bits 15:0, which is copied to div_o. The upper bits read as 0.
- R12: If a push and a pop reach the same queue in the same cycle, both take effect. The level stays the same and the byte order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered, valid the cycle after the read |
| tx_data_o | output | 8 | Head byte of the transmit queue |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_ready_i | input | 1 | Engine takes the transmit byte |
| rx_data_i | input | 8 | Byte received by the engine |
| rx_valid_i | input | 1 | Received byte is offered |
| rx_ready_o | output | 1 | Receive queue accepts a byte |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| two_stop_o | output | 1 | 1 = two stop bits |
| div_o | output | 16 | Clock divisor |
| irq_o | output | 1 | Masked watermark interrupt |

## Verification
Each queue can see a bus-side access and an engine-side access in the same cycle. On the transmit queue, a bus write can coincide with an engine pop. On the receive queue, a bus read can coincide with an engine push. The bench drives both events on the same clock edge. It then checks that the read returns the older byte, that no byte is lost or duplicated, and that the bytes still drain in order. An assertion also checks that the queue level does not change across such a cycle.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int REG_TXD  = 0;
  localparam int REG_RXD  = 1;
  localparam int REG_TXC  = 2;
  localparam int REG_RXC  = 3;
  localparam int REG_IE   = 4;
  localparam int REG_IP   = 5;
  localparam int REG_DIV  = 6;
  localparam int WM_LSB   = 16;
  localparam int WM_W     = 3;
  localparam int FLAG_BIT = 31;

  typedef struct packed {
    logic [WM_W-1:0] wm;
    logic            two_stop;
    logic            en;
  } tx_ctrl_t;

  typedef struct packed {
    logic [WM_W-1:0] wm;
    logic            en;
  } rx_ctrl_t;
endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[i] <= '0;
      else if (do_push && wr_ptr_q == PTR_W'(i))     mem_q[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/sio_wm_irq.sv
module sio_wm_irq #(
  parameter int CNT_W = 4,
  parameter int WM_W  = 3
) (
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [WM_W-1:0]  tx_wm_i,
  input  logic [WM_W-1:0]  rx_wm_i,
  input  logic [1:0]       ie_i,
  output logic [1:0]       ip_o,
  output logic             irq_o
);
  // opposite senses: tx fires on low level, rx on high level
  assign ip_o[0] = int'(tx_cnt_i) < int'(tx_wm_i);
  assign ip_o[1] = int'(rx_cnt_i) > int'(rx_wm_i);
  assign irq_o   = |(ip_o & ie_i);
endmodule

// File: rtl/sio_fifo_regs.sv
module sio_fifo_regs
  import sio_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 16,
  parameter int ADDR_W     = 5,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int IDX_W     = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              two_stop_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              irq_o
);
  tx_ctrl_t         tx_ctrl_q;
  rx_ctrl_t         rx_ctrl_q;
  logic [1:0]       ie_q, ip;
  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] sel;
  logic             wr, rd;
  logic             tx_push, tx_pop, rx_push, rx_pop, rx_rd;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [7:0]       rx_head;
  logic [31:0]      rd_data;
  logic             unused_bits;

  assign sel = bus_addr_i[ADDR_W-1:2];
  assign wr  = bus_req_i && bus_we_i;
  assign rd  = bus_req_i && !bus_we_i;
  assign unused_bits = ^{bus_addr_i[1:0], bus_wdata_i[31:WM_LSB+WM_W]};

  assign tx_push    = wr && sel == IDX_W'(REG_TXD) && !tx_full;
  assign tx_valid_o = tx_ctrl_q.en && !tx_empty;
  assign tx_pop     = tx_valid_o && tx_ready_i;
  assign rx_ready_o = rx_ctrl_q.en && !rx_full;
  assign rx_push    = rx_valid_i && rx_ready_o;
  assign rx_rd      = rd && sel == IDX_W'(REG_RXD);
  assign rx_pop     = rx_rd && !rx_empty;

  sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(bus_wdata_i[7:0]), .pop_i(tx_pop),
    .rdata_o(tx_data_o), .cnt_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(rx_data_i), .pop_i(rx_pop),
    .rdata_o(rx_head), .cnt_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  sio_wm_irq #(.CNT_W(CNT_W), .WM_W(WM_W)) u_irq (
    .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
    .tx_wm_i(tx_ctrl_q.wm), .rx_wm_i(rx_ctrl_q.wm),
    .ie_i(ie_q), .ip_o(ip), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ctrl_q <= '0;
      rx_ctrl_q <= '0;
      ie_q      <= '0;
      div_q     <= '0;
    end else if (wr) begin
      case (int'(sel))
        REG_TXC: tx_ctrl_q <= '{wm: bus_wdata_i[WM_LSB +: WM_W],
                                two_stop: bus_wdata_i[1], en: bus_wdata_i[0]};
        REG_RXC: rx_ctrl_q <= '{wm: bus_wdata_i[WM_LSB +: WM_W], en: bus_wdata_i[0]};
        REG_IE:  ie_q      <= bus_wdata_i[1:0];
        REG_DIV: div_q     <= bus_wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (int'(sel))
      REG_TXD: rd_data[FLAG_BIT] = tx_full;
      REG_RXD: begin
        rd_data[FLAG_BIT] = rx_empty;
        rd_data[7:0]      = rx_empty ? 8'h00 : rx_head;
      end
      REG_TXC: begin
        rd_data[WM_LSB +: WM_W] = tx_ctrl_q.wm;
        rd_data[1]              = tx_ctrl_q.two_stop;
        rd_data[0]              = tx_ctrl_q.en;
      end
      REG_RXC: begin
        rd_data[WM_LSB +: WM_W] = rx_ctrl_q.wm;
        rd_data[0]              = rx_ctrl_q.en;
      end
      REG_IE:  rd_data[1:0]       = ie_q;
      REG_IP:  rd_data[1:0]       = ip;
      REG_DIV: rd_data[DIV_W-1:0] = div_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  bus_rdata_o <= '0;
    else if (rd)  bus_rdata_o <= rd_data;
  end

  assign tx_en_o    = tx_ctrl_q.en;
  assign rx_en_o    = rx_ctrl_q.en;
  assign two_stop_o = tx_ctrl_q.two_stop;
  assign div_o      = div_q;
endmodule

// File: rtl/sio_fifo_regs_chk.sv
module sio_fifo_regs_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             tx_push,
  input logic             tx_pop,
  input logic             rx_push,
  input logic             rx_rd,
  input logic [1:0]       ie_q,
  input logic             tx_en_o,
  input logic             tx_valid_o,
  input logic             rx_ready_o,
  input logic             irq_o
);
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tx_cnt) <= DEPTH);
  a_r5_full_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rx_cnt) == DEPTH |-> !rx_ready_o);
  a_r2_tx_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> !tx_valid_o);
  a_r4_empty_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt == '0 && rx_rd && !rx_push) |=> rx_cnt == '0);
  a_r12_tx_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push && tx_pop) |=> $stable(tx_cnt));
  a_r10_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_q == 2'b00 |-> !irq_o);
endmodule

bind sio_fifo_regs sio_fifo_regs_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk_i, .rst_ni, .tx_cnt, .rx_cnt, .tx_push, .tx_pop, .rx_push, .rx_rd,
  .ie_q, .tx_en_o, .tx_valid_o, .rx_ready_o, .irq_o
);

// File: tb/sio_fifo_regs_tb.sv
module sio_fifo_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  tx_data, rx_data = '0;
  logic        tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
  logic        tx_en, rx_en, two_stop, irq;
  logic [15:0] div;
  int          n_chk = 0, n_bad = 0;

  localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_TXC = 5'h08,
                         A_RXC = 5'h0C, A_IE = 5'h10, A_IP = 5'h14, A_DIV = 5'h18;

  always #4 clk = ~clk;

  sio_fifo_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .two_stop_o(two_stop), .div_o(div), .irq_o(irq)
  );

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic rd_chk(logic [4:0] a, logic [31:0] exp, string rq);
    logic [31:0] d;
    rd_reg(a, d);
    check(rq, d, exp);
  endtask

  task automatic tx_take(logic [7:0] exp, string rq);
    check(rq, {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, exp});
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic rx_give(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 outputs", {28'd0, irq, tx_valid, rx_ready, tx_en}, 32'd0);
    rd_chk(A_TXD, 32'h0, "R1 txd");
    rd_chk(A_RXD, 32'h8000_0000, "R1 rxd");
    rd_chk(A_TXC, 32'h0, "R1 txc");
    rd_chk(A_RXC, 32'h0, "R1 rxc");
    rd_chk(A_IE, 32'h0, "R1 ie");
    rd_chk(A_IP, 32'h0, "R1 ip");
    rd_chk(A_DIV, 32'h0, "R1 div");
  endtask

  task automatic t_ctrl;
    wr_reg(A_TXC, 32'hFFFF_FFFF);
    rd_chk(A_TXC, 32'h0007_0003, "R6 txc readback");
    check("R6 outputs", {30'd0, tx_en, two_stop}, 32'd3);
    wr_reg(A_TXC, 32'h0005_0001);
    check("R6 one stop", {31'd0, two_stop}, 32'd0);
    wr_reg(A_RXC, 32'hFFFF_FFFF);
    rd_chk(A_RXC, 32'h0007_0001, "R7 rxc readback");
    check("R7 rx_en_o", {31'd0, rx_en}, 32'd1);
    wr_reg(A_DIV, 32'hABCD_1234);
    rd_chk(A_DIV, 32'h0000_1234, "R11 div readback");
    check("R11 div_o", {16'd0, div}, 32'h1234);
    wr_reg(A_RXC, 32'h0);
  endtask

  task automatic t_tx;
    wr_reg(A_TXC, 32'h0001_0000);
    wr_reg(A_TXD, 32'hFFFF_FFA1);
    wr_reg(A_TXD, 32'h0000_00A2);
    wr_reg(A_TXD, 32'h0000_00A3);
    check("R2 gated by enable", {31'd0, tx_valid}, 32'd0);
    rd_chk(A_IP, 32'h0, "R8 level 3 vs wm 1");
    wr_reg(A_TXC, 32'h0001_0001);
    tx_take(8'hA1, "R2 order 0");
    tx_take(8'hA2, "R2 order 1");
    tx_take(8'hA3, "R2 order 2");
    check("R2 drained", {31'd0, tx_valid}, 32'd0);
    rd_chk(A_IP, 32'h1, "R8 empty vs wm 1");
    wr_reg(A_TXC, 32'h0000_0001);
    rd_chk(A_IP, 32'h0, "R8 wm 0 never");
  endtask

  task automatic t_txfull;
    wr_reg(A_TXC, 32'h0000_0000);
    for (int i = 0; i < 9; i++) wr_reg(A_TXD, 32'h10 + i);
    rd_chk(A_TXD, 32'h8000_0000, "R3 full flag");
    wr_reg(A_TXC, 32'h0000_0001);
    for (int i = 0; i < 8; i++) tx_take(8'(8'h10 + i), "R3 kept bytes");
    check("R3 overflow byte dropped", {31'd0, tx_valid}, 32'd0);
    rd_chk(A_TXD, 32'h0, "R3 not full");
  endtask

  task automatic t_rx;
    wr_reg(A_RXC, 32'h0000_0001);
    check("R5 ready when enabled", {31'd0, rx_ready}, 32'd1);
    rx_give(8'h55);
    rx_give(8'h66);
    rd_chk(A_IP, 32'h2, "R9 level 2 vs wm 0");
    rd_chk(A_RXD, 32'h55, "R4 first");
    rd_chk(A_RXD, 32'h66, "R4 second");
    rd_chk(A_RXD, 32'h8000_0000, "R4 empty");
    rd_chk(A_RXD, 32'h8000_0000, "R4 empty again");
    rd_chk(A_IP, 32'h0, "R9 empty");
  endtask

  task automatic t_rxwm;
    wr_reg(A_RXC, 32'h0002_0001);
    rx_give(8'h01); rx_give(8'h02);
    rd_chk(A_IP, 32'h0, "R9 level 2 vs wm 2");
    rx_give(8'h03);
    rd_chk(A_IP, 32'h2, "R9 level 3 vs wm 2");
    for (int i = 1; i <= 3; i++) rd_chk(A_RXD, 32'(i), "R4 drain");
  endtask

  task automatic t_rxfull;
    wr_reg(A_RXC, 32'h0000_0001);
    for (int i = 0; i < 8; i++) rx_give(8'(8'h30 + i));
    check("R5 not ready when full", {31'd0, rx_ready}, 32'd0);
    rx_give(8'hEE);
    for (int i = 0; i < 8; i++) rd_chk(A_RXD, 32'h30 + i, "R5 contents");
    rd_chk(A_RXD, 32'h8000_0000, "R5 extra byte refused");
    wr_reg(A_RXC, 32'h0);
    check("R5 not ready when disabled", {31'd0, rx_ready}, 32'd0);
  endtask

  task automatic t_irq;
    wr_reg(A_TXC, 32'h0001_0001);
    wr_reg(A_RXC, 32'h0000_0001);
    wr_reg(A_IE, 32'h1);
    check("R10 tx source", {31'd0, irq}, 32'd1);
    wr_reg(A_IE, 32'h0);
    check("R10 masked", {31'd0, irq}, 32'd0);
    wr_reg(A_IP, 32'h0000_0002);
    rd_chk(A_IP, 32'h1, "R10 ip write ignored");
    wr_reg(A_IE, 32'h2);
    check("R10 rx idle", {31'd0, irq}, 32'd0);
    rx_give(8'h77);
    check("R10 rx source", {31'd0, irq}, 32'd1);
    rd_chk(A_RXD, 32'h77, "R10 pop");
    check("R10 rx cleared", {31'd0, irq}, 32'd0);
    wr_reg(A_IE, 32'h0);
  endtask

  task automatic t_concurrent;
    logic [31:0] d;
    wr_reg(A_TXC, 32'h0000_0001);
    wr_reg(A_TXD, 32'hD1);
    wr_reg(A_TXD, 32'hD2);
    @(negedge clk); req = 1; we = 1; addr = A_TXD; wdata = 32'hD3; tx_ready = 1;
    @(negedge clk); req = 0; we = 0; tx_ready = 0;
    tx_take(8'hD2, "R12 tx after overlap 0");
    tx_take(8'hD3, "R12 tx after overlap 1");
    check("R12 tx empty", {31'd0, tx_valid}, 32'd0);
    wr_reg(A_RXC, 32'h0000_0001);
    rx_give(8'hE1);
    @(negedge clk); req = 1; we = 0; addr = A_RXD; rx_valid = 1; rx_data = 8'hE2;
    @(negedge clk); req = 0; rx_valid = 0; d = rdata;
    check("R12 rx overlap read", d, 32'hE1);
    rd_chk(A_RXD, 32'hE2, "R12 rx kept");
    rd_chk(A_RXD, 32'h8000_0000, "R12 rx empty");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctrl();
    t_tx();
    t_txfull();
    t_rx();
    t_rxwm();
    t_rxfull();
    t_irq();
    t_concurrent();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule